// File: doc/BRIEF.md
# Signed-Digit Rail Converter

This block moves numbers between ordinary bit vectors and binary signed-digit vectors. A binary signed-digit vector is carried on two rails of equal width. A digit is -1 when only its negative-rail bit is set, +1 when only its positive-rail bit is set, and 0 when neither bit is set. The forward path turns an n-bit input into such a pair of rails. A mode input chooses whether that input is read as unsigned or as two's complement. The forward path is pure wiring and settles in the same cycle as its input.

The reverse path takes a pair of rails and gives back their value as an (n+1)-bit two's-complement word. That value is the positive rail read as an unsigned number, less the negative rail read as an unsigned number. The reverse path computes it with one subtraction across the full width. It also reports whether any digit position has both rail bits set, which is an illegal code. A parameter chooses whether the reverse result goes through an output register or leaves the block combinationally.

A datapath that keeps operands in signed-digit form uses the forward path when values come in and the reverse path when they go out.

Top module: `sdrail_conv`

## Requirements
- R1: When `fwd_signed` is 0 (unsigned mode), `fwd_neg` is all zeros and `fwd_pos` equals `fwd_in`, in the same cycle as the input.
- R2: When `fwd_signed` is 1 (two's-complement mode), bit n-1 of `fwd_neg` equals bit n-1 of `fwd_in` and every other bit of `fwd_neg` is 0. Bit n-1 of `fwd_pos` is 0 and bits n-2..0 of `fwd_pos` equal those of `fwd_in`. This holds in the same cycle as the input.
- R3: `rev_value`, read as (n+1)-bit two's complement, equals the unsigned value of `rev_pos` minus the unsigned value of `rev_neg`.
- R4: `rev_invalid` is 1 exactly when at least one bit position i has both `rev_neg[i]` and `rev_pos[i]` set.
- R5: An illegal digit does not change the value arithmetic. With every digit illegal, `rev_value` is 0 and `rev_invalid` is 1.
- R6: With the output register enabled (the default), `rev_value` and `rev_invalid` reflect the reverse inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are 0, whatever the inputs are.
- R7: Feeding the forward outputs into the reverse inputs returns the original number. In unsigned mode the input comes back zero-extended, and in two's-complement mode it comes back sign-extended, to n+1 bits. `rev_invalid` stays 0 in both cases.
- R8: At the range limits, all-ones `rev_pos` with all-zero `rev_neg` gives 2^n-1. All-ones `rev_neg` with all-zero `rev_pos` gives -(2^n-1), with bit n of `rev_value` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reverse-path output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| fwd_signed | input | 1 | Forward mode: 0 unsigned, 1 two's complement |
| fwd_in | input | WIDTH | Forward-path number |
| fwd_neg | output | WIDTH | Forward-path negative rail |
| fwd_pos | output | WIDTH | Forward-path positive rail |
| rev_neg | input | WIDTH | Reverse-path negative rail |
| rev_pos | input | WIDTH | Reverse-path positive rail |
| rev_value | output | WIDTH+1 | Reverse-path two's-complement value |
| rev_invalid | output | 1 | Some reverse-path digit carries both rail bits |

## Verification
The hardest case to reach is a reverse input whose digits mix +1, -1, 0 and the illegal code at the same time. Vectors that come out of the forward path never contain the illegal code, and they place a -1 only in the top position. For that reason the stimulus does more than loop every forward input back into the reverse path in both modes. It also drives the reverse rails directly with random and hand-picked patterns: rails that overlap, rails that are disjoint, and the extremes where all digits are +1 or all are -1. Each result is checked one cycle later against an integer difference that the bench computes on its own.

// File: rtl/sdrail_pkg.sv
package sdrail_pkg;

  typedef enum logic {
    SDR_UNSIGNED = 1'b0,
    SDR_TWOS     = 1'b1
  } sdr_mode_e;

endpackage

// File: rtl/sdrail_fwd.sv
module sdrail_fwd
  import sdrail_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             mode_signed,
  input  logic [WIDTH-1:0] num_in,
  output logic [WIDTH-1:0] neg_rail,
  output logic [WIDTH-1:0] pos_rail
);

  localparam int TOP = WIDTH - 1;

  sdr_mode_e mode;

  assign mode = sdr_mode_e'(mode_signed);

  // Only the top digit differs between modes: the sign weight moves to the
  // negative rail in two's-complement mode.
  always_comb begin
    neg_rail = '0;
    pos_rail = num_in;
    if (mode == SDR_TWOS) begin
      neg_rail[TOP] = num_in[TOP];
      pos_rail[TOP] = 1'b0;
    end
  end

endmodule

// File: rtl/sdrail_rev.sv
module sdrail_rev #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] neg_rail,
  input  logic [WIDTH-1:0] pos_rail,
  output logic [WIDTH:0]   diff,
  output logic             bad_digit
);

  localparam int OUTW = WIDTH + 1;

  // Rail difference as pos + ~neg + 1 over OUTW bits; both operands are
  // zero-extended first, so the inverted neg gets a 1 in the top bit.
  function automatic logic [OUTW-1:0] rail_diff(
    input logic [WIDTH-1:0] p,
    input logic [WIDTH-1:0] n
  );
    logic [OUTW-1:0] p_ext;
    logic [OUTW-1:0] n_inv;
    p_ext = {1'b0, p};
    n_inv = ~{1'b0, n};
    return p_ext + n_inv + {{WIDTH{1'b0}}, 1'b1};
  endfunction

  logic [WIDTH-1:0] both_set;

  for (genvar g = 0; g < WIDTH; g++) begin : g_digit
    assign both_set[g] = neg_rail[g] & pos_rail[g];
  end

  assign diff      = rail_diff(pos_rail, neg_rail);
  assign bad_digit = |both_set;

endmodule

// File: rtl/sdrail_outstage.sv
module sdrail_outstage #(
  parameter int WIDTH   = 8,
  parameter bit USE_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WIDTH:0] d_value,
  input  logic           d_flag,
  output logic [WIDTH:0] q_value,
  output logic           q_flag
);

  if (USE_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_value <= '0;
        q_flag  <= 1'b0;
      end else begin
        q_value <= d_value;
        q_flag  <= d_flag;
      end
    end
  end else begin : g_wire
    assign q_value = d_value;
    assign q_flag  = d_flag;
  end

endmodule

// File: rtl/sdrail_conv.sv
module sdrail_conv #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_signed,
  input  logic [WIDTH-1:0] fwd_in,
  output logic [WIDTH-1:0] fwd_neg,
  output logic [WIDTH-1:0] fwd_pos,
  input  logic [WIDTH-1:0] rev_neg,
  input  logic [WIDTH-1:0] rev_pos,
  output logic [WIDTH:0]   rev_value,
  output logic             rev_invalid
);

  // Named internal events for the checker.
  logic [WIDTH:0] rev_diff_comb;
  logic           rev_bad_comb;

  sdrail_fwd #(.WIDTH(WIDTH)) u_fwd (
    .mode_signed (fwd_signed),
    .num_in      (fwd_in),
    .neg_rail    (fwd_neg),
    .pos_rail    (fwd_pos)
  );

  sdrail_rev #(.WIDTH(WIDTH)) u_rev (
    .neg_rail  (rev_neg),
    .pos_rail  (rev_pos),
    .diff      (rev_diff_comb),
    .bad_digit (rev_bad_comb)
  );

  sdrail_outstage #(.WIDTH(WIDTH), .USE_REG(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_value (rev_diff_comb),
    .d_flag  (rev_bad_comb),
    .q_value (rev_value),
    .q_flag  (rev_invalid)
  );

endmodule

// File: rtl/sdrail_checker.sv
module sdrail_checker #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fwd_signed,
  input logic [WIDTH-1:0] fwd_in,
  input logic [WIDTH-1:0] fwd_neg,
  input logic [WIDTH-1:0] fwd_pos,
  input logic [WIDTH-1:0] rev_neg,
  input logic [WIDTH-1:0] rev_pos,
  input logic [WIDTH:0]   rev_value,
  input logic             rev_invalid,
  input logic [WIDTH:0]   rev_diff_comb,
  input logic             rev_bad_comb
);

  assert_fwd_unsigned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_signed |-> (fwd_neg == '0 && fwd_pos == fwd_in));

  assert_fwd_signed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_signed |-> ($countones(fwd_neg) <= 1 && !fwd_pos[WIDTH-1] &&
      ($signed({1'b0, fwd_pos}) - $signed({1'b0, fwd_neg}) ==
       $signed({fwd_in[WIDTH-1], fwd_in}))));

  if (REG_OUT) begin : g_reg_chk
    assert_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rev_value + {1'b0, $past(rev_neg)} == {1'b0, $past(rev_pos)}));

    assert_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rev_invalid == ($past(rev_neg & rev_pos) != '0)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rev_value == $past(rev_diff_comb) && rev_invalid == $past(rev_bad_comb)));

    assert_reset_zero_R6: assert property (@(posedge clk)
      !rst_n |=> (rev_value == '0 && !rev_invalid));
  end else begin : g_comb_chk
    assert_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rev_value + {1'b0, rev_neg} == {1'b0, rev_pos});

    assert_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rev_invalid == ((rev_neg & rev_pos) != '0));
  end

endmodule

bind sdrail_conv sdrail_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fwd_signed    (fwd_signed),
  .fwd_in        (fwd_in),
  .fwd_neg       (fwd_neg),
  .fwd_pos       (fwd_pos),
  .rev_neg       (rev_neg),
  .rev_pos       (rev_pos),
  .rev_value     (rev_value),
  .rev_invalid   (rev_invalid),
  .rev_diff_comb (rev_diff_comb),
  .rev_bad_comb  (rev_bad_comb)
);

// File: tb/sdrail_conv_tb.sv
`timescale 1ns/100ps
module sdrail_conv_tb_top;

  localparam int W = 8;
  localparam int WATCHDOG_NS = 400000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fwd_signed = 1'b0;
  logic [W-1:0] fwd_in = '0;
  logic [W-1:0] fwd_neg, fwd_pos;
  logic         loop_sel = 1'b0;
  logic [W-1:0] drv_neg = '0, drv_pos = '0;
  logic [W-1:0] rev_neg, rev_pos;
  logic [W:0]   rev_value;
  logic         rev_invalid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W:0] val;
    logic       inv;
    int         stamp;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  assign rev_neg = loop_sel ? fwd_neg : drv_neg;
  assign rev_pos = loop_sel ? fwd_pos : drv_pos;

  sdrail_conv #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_signed  (fwd_signed),
    .fwd_in      (fwd_in),
    .fwd_neg     (fwd_neg),
    .fwd_pos     (fwd_pos),
    .rev_neg     (rev_neg),
    .rev_pos     (rev_pos),
    .rev_value   (rev_value),
    .rev_invalid (rev_invalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [W:0] to_word(input int v);
    return v[W:0];
  endfunction

  // Driver: one stimulus per clock, forward checked at once, reverse queued.
  task automatic drive(input logic sgn, input logic [W-1:0] num, input logic lp,
                       input logic [W-1:0] n_r, input logic [W-1:0] p_r, input string req);
    exp_t e;
    int   v;
    logic [W-1:0] en, ep;
    @(posedge clk);
    #0.5;
    fwd_signed = sgn;
    fwd_in     = num;
    loop_sel   = lp;
    drv_neg    = n_r;
    drv_pos    = p_r;
    #0.5;
    if (!sgn) begin
      check("R1 neg", 32'(fwd_neg), 32'(0));
      check("R1 pos", 32'(fwd_pos), 32'(num));
    end else begin
      en = '0; en[W-1] = num[W-1];
      ep = num;  ep[W-1] = 1'b0;
      check("R2 neg", 32'(fwd_neg), 32'(en));
      check("R2 pos", 32'(fwd_pos), 32'(ep));
    end
    if (lp) begin
      v = sgn ? int'($signed(num)) : int'(num);
      e.inv = 1'b0;
    end else begin
      v = int'(p_r) - int'(n_r);
      e.inv = ((n_r & p_r) != '0);
    end
    e.val   = to_word(v);
    e.stamp = cyc;
    e.req   = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compares registered results one edge after their stimulus.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2.5;
      if (rst_n && sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
        e = sb_q.pop_front();
        check({e.req, " value"}, 32'(rev_value), 32'(e.val));
        check({e.req, " invalid"}, 32'(rev_invalid), 32'(e.inv));
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG_NS);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] old_val;
    // R6: reset holds outputs at zero even with live inputs.
    drv_pos = '1;
    drv_neg = 8'h0F;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset value", 32'(rev_value), 32'(0));
    check("R6 reset invalid", 32'(rev_invalid), 32'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R7: exhaustive round trip in both modes.
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < (1 << W); k++) begin
        drive(m[0], k[W-1:0], 1'b1, '0, '0, m ? "R7 signed" : "R7 unsigned");
      end
    end

    // R8: range limits.
    drive(1'b0, '0, 1'b0, '0, '1, "R8 max");
    drive(1'b0, '0, 1'b0, '1, '0, "R8 min");
    // R5: all digits illegal.
    drive(1'b0, '0, 1'b0, '1, '1, "R5 all illegal");
    // R4: one illegal digit at each end.
    drive(1'b0, '0, 1'b0, 8'h01, 8'h01, "R4 low illegal");
    drive(1'b0, '0, 1'b0, 8'h80, 8'hF0, "R4 high illegal");
    drive(1'b0, '0, 1'b0, 8'h55, 8'hAA, "R4 disjoint");

    // R6: output must not move before the next edge.
    drive(1'b0, '0, 1'b0, '0, 8'h11, "R6 latency a");
    @(posedge clk);
    #0.5;
    old_val    = rev_value[W-1:0];
    loop_sel   = 1'b0;
    drv_neg    = '0;
    drv_pos    = 8'h22;
    #1;
    check("R6 held before edge", 32'(rev_value), 32'(old_val));
    @(posedge clk);
    #1;
    check("R6 updated after edge", 32'(rev_value), 32'h22);

    // R3: random digit vectors, some with illegal codes (R4).
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] rn, rp;
      rn = W'($urandom);
      rp = W'($urandom);
      if (k % 2 == 0) rp = rp & ~rn;
      drive(k[0], W'($urandom), 1'b0, rn, rp, "R3 random");
    end

    repeat (4) @(posedge clk);
    #1;
    check("R3 scoreboard drained", 32'(sb_q.size()), 32'(0));
    finish_run();
  end

endmodule